// File: doc/BRIEF.md
# External Interrupt Edge and Source Selector

This block turns six external interrupt pins into sticky interrupt request flags. Each pin passes through a synchroniser and an edge detector. A per-line polarity input picks the falling or the rising edge. A per-pin mode bit can instead make the line trigger on both edges. Request lines 0 to 3 always follow pins 0 to 3. Lines 4 and 5 are shared lines. Each one is driven either by its own external pin or by one of two internal peripheral events, and register bits pick which.

Software configures the block through two 8-bit registers, each with a write strobe and a readback port. The cause register holds the six both-edge bits and the two shared-line source bits. The pick register chooses which peripheral event feeds each shared line when that line is not on its pin. The interrupt controller reads each flag and clears it with a one-cycle clear pulse. Vector fetch and priority logic sit outside the block.

Top module: `xirq_route`

## Requirements
- R1: After reset the cause register reads 0x00, the pick register reads 0x00 and all six request flags are 0.
- R2: A write strobe loads the 8-bit write data into its register, and the value can be read back on the following clock. The cause register and the pick register each have their own strobe, and all 8 bits of each register read back.
- R3: When cause bit k (k = 0..5) is 0 and line k is on its pin, a polarity input of 0 sets the flag on a falling pin edge and 1 sets it on a rising edge. The flag goes high on the third rising clock edge after the pin changes, and the opposite edge is ignored.
- R4: When cause bit k is 1 and line k is on its pin, both a rising and a falling pin edge set flag k.
- R5: Line 4 takes pin 4 when cause bit 6 is 1. When cause bit 6 is 0 it takes a peripheral event: transmit-done if pick bit 0 is 0, serial channel 3 if pick bit 0 is 1. Sources that are not selected have no effect on flag 4.
- R6: Line 5 takes pin 5 when cause bit 7 is 1. When cause bit 7 is 0 it takes a peripheral event: receive-done if pick bit 3 is 0, serial channel 4 if pick bit 3 is 1. Sources that are not selected have no effect on flag 5.
- R7: Peripheral events are not synchronised. A qualifying peripheral edge sets the flag on the first rising clock edge after the change. Peripheral sources always use single-edge detection set by the line's polarity input, even when the line's both-edge bit is 1.
- R8: A flag stays set until its clear input is high at a clock edge. If a qualifying edge and a clear fall in the same cycle, the flag ends up set.
- R9: Changing a cause source bit or a pick bit never sets a flag by itself. This holds even when the newly selected source has a different level from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous external interrupt pins 0..5 |
| txdone_i | input | 1 | Transmit-done event (line 4 peripheral choice 0) |
| ser3_i | input | 1 | Serial channel 3 event (line 4 peripheral choice 1) |
| rxdone_i | input | 1 | Receive-done event (line 5 peripheral choice 0) |
| ser4_i | input | 1 | Serial channel 4 event (line 5 peripheral choice 1) |
| pol_i | input | 6 | Per-line polarity: 0 falling, 1 rising |
| clr_i | input | 6 | Per-line flag clear |
| sel_we | input | 1 | Cause register write strobe |
| sel_wdata | input | 8 | Cause register write data |
| sel_rdata | output | 8 | Cause register readback |
| pick_we | input | 1 | Pick register write strobe |
| pick_wdata | input | 8 | Pick register write data |
| pick_rdata | output | 8 | Pick register readback |
| req_o | output | 6 | Sticky request flags, one per line |

## Verification
The bench switches a shared line's source while the old source and the new source sit at different levels. A design that does not suppress detection in that cycle raises a spurious request. It checks the latency of both paths: pins take three clock edges and peripheral events take one. An extra or a missing synchroniser stage shows up as a flag one cycle early or late. It also sets the both-edge bit on a line that is on a peripheral event, to catch a design that applies both-edge mode to peripherals. Finally it lands a clear in the same cycle as a new edge, which exposes a design where the clear wins and drops the request.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int NUM_PINS   = 6;
    localparam int NUM_LINES  = 6;
    localparam int REG_W      = 8;
    localparam int LINE_A     = 4;
    localparam int LINE_B     = 5;
    localparam int NUM_SHARED = NUM_LINES - LINE_A;
    localparam int PICK_A_BIT = 0;
    localparam int PICK_B_BIT = 3;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic                b_ext;
        logic                a_ext;
        logic [NUM_PINS-1:0] dual;
    } cause_t;

    typedef enum logic [1:0] {
        SRC_PIN  = 2'd0,
        SRC_PER0 = 2'd1,
        SRC_PER1 = 2'd2
    } src_e;

    function automatic src_e shared_src(input logic ext, input logic pick);
        if (ext)       return SRC_PIN;
        else if (pick) return SRC_PER1;
        else           return SRC_PER0;
    endfunction

    function automatic logic edge_hit(input logic cur, input logic prev,
                                      input logic pol, input logic dual);
        if (dual)     return cur ^ prev;
        else if (pol) return cur & ~prev;
        else          return ~cur & prev;
    endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg
    import xirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [REG_W-1:0] sel_wdata,
    input  logic             pick_we,
    input  logic [REG_W-1:0] pick_wdata,
    output cause_t           cause,
    output logic [REG_W-1:0] pick_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause  <= '0;
            pick_q <= '0;
        end else begin
            if (sel_we)  cause  <= cause_t'(sel_wdata);
            if (pick_we) pick_q <= pick_wdata;
        end
    end
endmodule

// File: rtl/xirq_edge.sv
module xirq_edge
    import xirq_pkg::*;
#(
    parameter src_e ROUTE_RST = SRC_PIN
) (
    input  logic clk,
    input  logic rst,
    input  logic cur,
    input  src_e route,
    input  logic dual,
    input  logic pol,
    input  logic clr,
    output logic req
);
    logic prev_q;
    src_e route_q;
    logic hit;

    // a route change reloads history without reporting an edge
    always_comb hit = (route == route_q) && edge_hit(cur, prev_q, pol, dual);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            route_q <= ROUTE_RST;
            req     <= 1'b0;
        end else begin
            prev_q  <= cur;
            route_q <= route;
            req     <= (req & ~clr) | hit;
        end
    end
endmodule

// File: rtl/xirq_route.sv
module xirq_route
    import xirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic                 txdone_i,
    input  logic                 ser3_i,
    input  logic                 rxdone_i,
    input  logic                 ser4_i,
    input  logic [NUM_LINES-1:0] pol_i,
    input  logic [NUM_LINES-1:0] clr_i,
    input  logic                 sel_we,
    input  logic [REG_W-1:0]     sel_wdata,
    output logic [REG_W-1:0]     sel_rdata,
    input  logic                 pick_we,
    input  logic [REG_W-1:0]     pick_wdata,
    output logic [REG_W-1:0]     pick_rdata,
    output logic [NUM_LINES-1:0] req_o
);
    cause_t                cause;
    logic [REG_W-1:0]      pick_q;
    logic [NUM_PINS-1:0]   pin_s;
    logic [NUM_SHARED-1:0] sh_ext, sh_pick, sh_per0, sh_per1;

    xirq_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .pick_we    (pick_we),
        .pick_wdata (pick_wdata),
        .cause      (cause),
        .pick_q     (pick_q)
    );

    xirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_s)
    );

    assign sel_rdata  = cause;
    assign pick_rdata = pick_q;
    assign sh_ext     = {cause.b_ext, cause.a_ext};
    assign sh_pick    = {pick_q[PICK_B_BIT], pick_q[PICK_A_BIT]};
    assign sh_per0    = {rxdone_i, txdone_i};
    assign sh_per1    = {ser4_i, ser3_i};

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        src_e rt;
        logic cur;
        logic dual_eff;

        if (k >= LINE_A) begin : g_shared
            localparam int J = k - LINE_A;
            always_comb begin
                rt = shared_src(sh_ext[J], sh_pick[J]);
                case (rt)
                    SRC_PIN:  cur = pin_s[k];
                    SRC_PER1: cur = sh_per1[J];
                    default:  cur = sh_per0[J];
                endcase
                // peripheral sources are single-edge only
                dual_eff = (rt == SRC_PIN) & cause.dual[k];
            end
        end else begin : g_direct
            always_comb begin
                rt       = SRC_PIN;
                cur      = pin_s[k];
                dual_eff = cause.dual[k];
            end
        end

        xirq_edge #(.ROUTE_RST(src_e'((k >= LINE_A) ? SRC_PER0 : SRC_PIN))) u_edge (
            .clk   (clk),
            .rst   (rst),
            .cur   (cur),
            .route (rt),
            .dual  (dual_eff),
            .pol   (pol_i[k]),
            .clr   (clr_i[k]),
            .req   (req_o[k])
        );
    end
endmodule

// File: rtl/xirq_route_chk.sv
module xirq_route_chk
    import xirq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 txdone_i,
    input logic [NUM_LINES-1:0] pol_i,
    input logic [NUM_LINES-1:0] clr_i,
    input logic                 sel_we,
    input logic [REG_W-1:0]     sel_wdata,
    input logic [REG_W-1:0]     sel_rdata,
    input logic                 pick_we,
    input logic [REG_W-1:0]     pick_wdata,
    input logic [REG_W-1:0]     pick_rdata,
    input logic [NUM_LINES-1:0] req_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (req_o == '0 && sel_rdata == '0 && pick_rdata == '0)); // R1

    AST_SEL_READBACK: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (sel_rdata == $past(sel_wdata))); // R2

    AST_PICK_READBACK: assert property (@(posedge clk) disable iff (rst)
        pick_we |=> (pick_rdata == $past(pick_wdata))); // R2

    AST_PERIPH_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
        (!sel_rdata[6] && !pick_rdata[PICK_A_BIT] && !$past(sel_rdata[6]) &&
         !$past(pick_rdata[PICK_A_BIT]) && !pol_i[LINE_A] &&
         $past(txdone_i) && !txdone_i) |=> req_o[LINE_A]); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(req_o & ~clr_i)) |=> (((($past(req_o) & ~$past(clr_i))) & ~req_o) == '0)); // R8

    AST_SRC_SWITCH_QUIET_A: assert property (@(posedge clk) disable iff (rst)
        (sel_rdata[6] != $past(sel_rdata[6])) |=>
        (req_o[LINE_A] == ($past(req_o[LINE_A]) & ~$past(clr_i[LINE_A])))); // R9

    AST_SRC_SWITCH_QUIET_B: assert property (@(posedge clk) disable iff (rst)
        (sel_rdata[7] != $past(sel_rdata[7])) |=>
        (req_o[LINE_B] == ($past(req_o[LINE_B]) & ~$past(clr_i[LINE_B])))); // R9

    AST_PICK_SWITCH_QUIET_A: assert property (@(posedge clk) disable iff (rst)
        (!sel_rdata[6] && (pick_rdata[PICK_A_BIT] != $past(pick_rdata[PICK_A_BIT]))) |=>
        (req_o[LINE_A] == ($past(req_o[LINE_A]) & ~$past(clr_i[LINE_A])))); // R9
endmodule

bind xirq_route xirq_route_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .txdone_i   (txdone_i),
    .pol_i      (pol_i),
    .clr_i      (clr_i),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .sel_rdata  (sel_rdata),
    .pick_we    (pick_we),
    .pick_wdata (pick_wdata),
    .pick_rdata (pick_rdata),
    .req_o      (req_o)
);

// File: tb/sim_xirq_route.sv
`timescale 1ns/1ps
module sim_xirq_route;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] pin, pol, clr;
    logic       txd, ser3, rxd, ser4;
    logic       sel_we, pick_we;
    logic [7:0] sel_wd, pick_wd;
    logic [7:0] sel_rd, pick_rd;
    logic [5:0] req;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;
    string phase    = "R1";

    always #4 clk = ~clk;

    xirq_route u0 (
        .clk(clk), .rst(rst), .pin_i(pin),
        .txdone_i(txd), .ser3_i(ser3), .rxdone_i(rxd), .ser4_i(ser4),
        .pol_i(pol), .clr_i(clr),
        .sel_we(sel_we), .sel_wdata(sel_wd), .sel_rdata(sel_rd),
        .pick_we(pick_we), .pick_wdata(pick_wd), .pick_rdata(pick_rd),
        .req_o(req)
    );

    // ---------------- behavioural reference model ----------------
    bit [5:0] m_s1, m_s2, m_req, nreq, m_prev;
    int       m_route [6];
    bit [7:0] m_cause, m_pick;
    int       r;
    bit       c, ext, pk, dual, hit;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_req = '0; m_prev = '0;
            m_cause = '0; m_pick = '0;
            for (int k = 0; k < 6; k++) m_route[k] = (k >= 4) ? 1 : 0;
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (k < 4) begin
                    r = 0; c = m_s2[k];
                end else begin
                    ext = (k == 4) ? m_cause[6] : m_cause[7];
                    pk  = (k == 4) ? m_pick[0]  : m_pick[3];
                    if (ext)     begin r = 0; c = m_s2[k]; end
                    else if (pk) begin r = 2; c = (k == 4) ? ser3 : ser4; end
                    else         begin r = 1; c = (k == 4) ? txd : rxd; end
                end
                dual = (r == 0) ? m_cause[k] : 1'b0;
                hit  = 1'b0;
                if (r == m_route[k]) begin
                    if (dual)        hit = (c != m_prev[k]);
                    else if (pol[k]) hit = c && !m_prev[k];
                    else             hit = !c && m_prev[k];
                end
                nreq[k]    = (m_req[k] && !clr[k]) || hit;
                m_prev[k]  = c;
                m_route[k] = r;
            end
            m_req = nreq;
            m_s2  = m_s1;
            m_s1  = pin;
            if (sel_we)  m_cause = sel_wd;
            if (pick_we) m_pick  = pick_wd;
        end
    end

    task automatic check_val(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check_val({phase, " model flags"},     {2'b00, req}, {2'b00, m_req});
            check_val({phase, " model cause reg"}, sel_rd,  m_cause);
            check_val({phase, " model pick reg"},  pick_rd, m_pick);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sel(input logic [7:0] v);
        sel_wd = v; sel_we = 1'b1; tick(1); sel_we = 1'b0;
    endtask

    task automatic wr_pick(input logic [7:0] v);
        pick_wd = v; pick_we = 1'b1; tick(1); pick_we = 1'b0;
    endtask

    task automatic pulse_clr(input int k);
        clr[k] = 1'b1; tick(1); clr[k] = 1'b0;
    endtask

    initial begin
        #(8 * 60000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog phase %s actual=running expected=finished", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin = '0; pol = '0; clr = '0;
        txd = 1'b0; ser3 = 1'b0; rxd = 1'b0; ser4 = 1'b0;
        sel_we = 1'b0; pick_we = 1'b0; sel_wd = '0; pick_wd = '0;
        tick(3); rst = 1'b0; tick(1);

        // R1 reset state
        check_val("R1 flags after reset", {2'b00, req}, 8'h00);
        check_val("R1 cause reg after reset", sel_rd, 8'h00);
        check_val("R1 pick reg after reset", pick_rd, 8'h00);

        // R2 register readback
        phase = "R2";
        wr_sel(8'hA5);   check_val("R2 cause readback", sel_rd, 8'hA5);
        wr_pick(8'h3C);  check_val("R2 pick readback", pick_rd, 8'h3C);
        wr_sel(8'h00);   wr_pick(8'h00); tick(2);
        clr = 6'h3F; tick(1); clr = '0;

        // R3 single edge with polarity
        phase = "R3";
        pin[0] = 1'b1; tick(5);
        check_val("R3 rising ignored pol0", {7'b0, req[0]}, 8'h00);
        pin[0] = 1'b0; tick(2);
        check_val("R3 no flag before third edge", {7'b0, req[0]}, 8'h00);
        tick(1);
        check_val("R3 falling sets on third edge", {7'b0, req[0]}, 8'h01);
        pulse_clr(0);
        pol[1] = 1'b1; pin[1] = 1'b1; tick(5);
        check_val("R3 rising sets pol1", {7'b0, req[1]}, 8'h01);
        pulse_clr(1); pin[1] = 1'b0; tick(5);
        check_val("R3 falling ignored pol1", {7'b0, req[1]}, 8'h00);
        pol[1] = 1'b0;

        // R4 both edges
        phase = "R4";
        wr_sel(8'h04);
        pin[2] = 1'b1; tick(5);
        check_val("R4 rising sets in dual mode", {7'b0, req[2]}, 8'h01);
        pulse_clr(2); pin[2] = 1'b0; tick(5);
        check_val("R4 falling sets in dual mode", {7'b0, req[2]}, 8'h01);
        pulse_clr(2); wr_sel(8'h00);

        // R5 line 4 routing
        phase = "R5";
        txd = 1'b1; tick(2);
        check_val("R5 tx rising ignored", {7'b0, req[4]}, 8'h00);
        txd = 1'b0; tick(1);
        check_val("R5 tx falling sets line4", {7'b0, req[4]}, 8'h01);
        pulse_clr(4);
        wr_pick(8'h01);
        txd = 1'b1; tick(2); txd = 1'b0; tick(2);
        check_val("R5 tx ignored when ser3 picked", {7'b0, req[4]}, 8'h00);
        ser3 = 1'b1; tick(2); ser3 = 1'b0; tick(1);
        check_val("R5 ser3 falling sets line4", {7'b0, req[4]}, 8'h01);
        pulse_clr(4);
        wr_sel(8'h40);
        ser3 = 1'b1; tick(2); ser3 = 1'b0; tick(2);
        check_val("R5 ser3 ignored when pin4 selected", {7'b0, req[4]}, 8'h00);
        pin[4] = 1'b1; tick(4); pin[4] = 1'b0; tick(4);
        check_val("R5 pin4 falling sets line4", {7'b0, req[4]}, 8'h01);
        pulse_clr(4); wr_sel(8'h00); wr_pick(8'h00);

        // R6 line 5 routing
        phase = "R6";
        rxd = 1'b1; tick(2); rxd = 1'b0; tick(1);
        check_val("R6 rx falling sets line5", {7'b0, req[5]}, 8'h01);
        pulse_clr(5);
        wr_pick(8'h08);
        rxd = 1'b1; tick(2); rxd = 1'b0; tick(2);
        check_val("R6 rx ignored when ser4 picked", {7'b0, req[5]}, 8'h00);
        ser4 = 1'b1; tick(2); ser4 = 1'b0; tick(1);
        check_val("R6 ser4 falling sets line5", {7'b0, req[5]}, 8'h01);
        pulse_clr(5);
        wr_sel(8'h80);
        pin[5] = 1'b1; tick(4); pin[5] = 1'b0; tick(4);
        check_val("R6 pin5 falling sets line5", {7'b0, req[5]}, 8'h01);
        pulse_clr(5);
        ser4 = 1'b1; tick(2); ser4 = 1'b0; tick(2);
        check_val("R6 ser4 ignored when pin5 selected", {7'b0, req[5]}, 8'h00);
        wr_sel(8'h00); wr_pick(8'h00);

        // R7 peripheral path: one edge latency, dual bit ignored
        phase = "R7";
        wr_sel(8'h10);
        txd = 1'b1; tick(2);
        check_val("R7 dual bit ignored on peripheral", {7'b0, req[4]}, 8'h00);
        txd = 1'b0; tick(1);
        check_val("R7 peripheral sets on next edge", {7'b0, req[4]}, 8'h01);
        pulse_clr(4); wr_sel(8'h00);

        // R8 sticky, clear, set wins
        phase = "R8";
        txd = 1'b1; tick(2); txd = 1'b0; tick(4);
        check_val("R8 flag holds", {7'b0, req[4]}, 8'h01);
        pulse_clr(4);
        check_val("R8 clear drops flag", {7'b0, req[4]}, 8'h00);
        txd = 1'b1; tick(2);
        txd = 1'b0; clr[4] = 1'b1; tick(1); clr[4] = 1'b0;
        check_val("R8 set wins over clear", {7'b0, req[4]}, 8'h01);
        pulse_clr(4);

        // R9 select changes are silent
        phase = "R9";
        txd = 1'b1; ser3 = 1'b0; tick(2);
        wr_pick(8'h01); tick(3);
        check_val("R9 pick change no request", {7'b0, req[4]}, 8'h00);
        ser3 = 1'b1; tick(2);
        wr_sel(8'h40); tick(3);
        check_val("R9 cause source change no request", {7'b0, req[4]}, 8'h00);
        rxd = 1'b1; tick(2);
        wr_sel(8'hC0); tick(3);
        check_val("R9 line5 source change no request", {7'b0, req[5]}, 8'h00);
        wr_sel(8'h00); wr_pick(8'h00); tick(3);
        check_val("R9 switch back no request", {2'b00, req}, 8'h00);

        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule